// File: doc/BRIEF.md
# Ethernet frame transmitter for a 32-bit four-lane XGMII-style bus

This block takes Ethernet frames that are already buffered upstream and sends them out on a 32-bit data bus with a 4-bit control bus. Each data byte has its own lane and its own control bit. For every frame it sends a start word, then a preamble word that ends in the delimiter, then the payload four bytes per cycle. The terminate code goes in the lane just after the last valid byte. Idle codes fill the bus between frames.

Frames come in over a ready/valid word stream. Each frame is a length word, then a release-timestamp word, then its payload words. In back-to-back mode a frame starts as soon as its header has been taken. In paced mode the frame waits in idle until a free-running cycle counter, which starts at reset, reaches the frame's timestamp. The frame whose length word is tagged as final ends the run: the block then raises a done flag and drives idle codes until it is reset.

Top module: `xgmii_frame_tx`

## Requirements
- R1: During reset, and in any cycle with no frame on the bus, the block drives data 0x07070707 with control 0xF. Reset clears the cycle counter and the done flag.
- R2: A frame opens with the word 0x555555FB and control 0x1, so the start code sits alone in lane 0. The next cycle carries 0xD5555555 with control 0x0.
- R3: While at least 4 payload bytes remain, each cycle carries a full payload word with control 0x0. Payload byte 0 of a word sits in bits [7:0].
- R4: With 3 bytes left, lanes 0 to 2 carry those bytes and lane 3 carries 0xFD, with control 0x8.
- R5: With 2 bytes left, lanes 0 and 1 carry those bytes, lane 2 carries 0xFD and lane 3 carries 0x07, with control 0xC.
- R6: With 1 byte left, lane 0 carries it, lane 1 carries 0xFD and lanes 2 and 3 carry 0x07, with control 0xE.
- R7: With 0 bytes left (the length is a multiple of 4), a separate word 0x070707FD with control 0xF ends the frame.
- R8: Input words arrive in this order: a length word (byte count in bits [15:0], in_final_i tags the last frame), then a 32-bit release timestamp, then ceil(length/4) payload words. A word is taken on a rising edge where in_valid_i and in_ready_o are both high.
- R9: In back-to-back mode, when input words are always valid, exactly two idle words separate a frame's terminate word from the next start word.
- R10: In paced mode, counting rising edges since reset was released, the start word first appears in the cycle numbered timestamp+2, provided the header was taken earlier. Idle codes fill the bus until then. A timestamp already passed gives the back-to-back spacing.
- R11: From the cycle after the final frame's terminate word, done_o is high, in_ready_o is low and the bus carries idle codes, until reset.
- R12: In any cycle where a payload word is due but in_valid_i is low, the bus carries the error word 0xFEFEFEFE with control 0xF. The frame then resumes with the word once it arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| paced_i | input | 1 | 1 = hold each frame until its release time, 0 = back-to-back |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 32 | Input word: length, timestamp or payload |
| in_final_i | input | 1 | With a length word: this frame is the last one |
| in_ready_o | output | 1 | Block takes the input word on this edge |
| txd_o | output | 32 | Bus data, lane n in bits [8n+7:8n] |
| txc_o | output | 4 | Bus control, bit n marks lane n as a control code |
| done_o | output | 1 | All frames sent |

## Verification
The bench sends frames whose lengths cover every remainder modulo 4, including a zero-length frame. A packer that miscounted lanes would put the terminate code one lane early or late, or would drop the separate terminate word when the length is a multiple of 4. The gap between frames is counted, so a state machine that skipped or added an idle cycle shows up. The paced run checks the exact cycle of the start word and uses a timestamp that has already passed. A counter that was not cleared by reset, or a comparison that was off by one, moves that cycle. A payload word is held back in the middle of a frame, so a design that sent stale data or idle codes there, or lost a word, fails. Done is checked for staying high with no input taken afterwards.

// File: rtl/xgtx_pkg.sv
package xgtx_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned DW    = 8 * LANES;
  localparam int unsigned TS_W  = 32;

  localparam logic [7:0] C_IDLE  = 8'h07;
  localparam logic [7:0] C_START = 8'hFB;
  localparam logic [7:0] C_TERM  = 8'hFD;
  localparam logic [7:0] C_ERR   = 8'hFE;
  localparam logic [7:0] C_PRE   = 8'h55;
  localparam logic [7:0] C_SFD   = 8'hD5;

  typedef enum logic [2:0] {
    S_LEN, S_TS, S_WAIT, S_SOF, S_PRE, S_DATA, S_DONE
  } st_e;
endpackage

// File: rtl/xgtx_timer.sv
module xgtx_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] ts_i,
  output logic             reached_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign reached_o = (cnt_q >= ts_i);
endmodule

// File: rtl/xgtx_lane_pack.sv
module xgtx_lane_pack
  import xgtx_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic [LEN_W-1:0] rem_i,
  input  logic [DW-1:0]    word_i,
  output logic [DW-1:0]    txd_o,
  output logic [LANES-1:0] txc_o
);
  logic       full;
  logic [1:0] nb;

  assign full = (rem_i >= LEN_W'(LANES));
  assign nb   = rem_i[1:0];

  // data lanes below the byte count, terminate in the next lane, idle above
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic is_data;
    assign is_data        = full || (2'(l) < nb);
    assign txd_o[8*l +: 8] = is_data ? word_i[8*l +: 8]
                           : ((2'(l) == nb) ? C_TERM : C_IDLE);
    assign txc_o[l]        = !is_data;
  end
endmodule

// File: rtl/xgmii_frame_tx.sv
module xgmii_frame_tx
  import xgtx_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          paced_i,
  input  logic          in_valid_i,
  input  logic [31:0]   in_data_i,
  input  logic          in_final_i,
  output logic          in_ready_o,
  output logic [31:0]   txd_o,
  output logic [3:0]    txc_o,
  output logic          done_o
);
  localparam logic [DW-1:0]    W_IDLE = {LANES{C_IDLE}};
  localparam logic [DW-1:0]    W_ERR  = {LANES{C_ERR}};
  localparam logic [DW-1:0]    W_SOF  = {C_PRE, C_PRE, C_PRE, C_START};
  localparam logic [DW-1:0]    W_PRE  = {C_SFD, C_PRE, C_PRE, C_PRE};
  localparam logic [LANES-1:0] K_ALL  = '1;

  st_e              st_q, st_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             fin_q, fin_d;
  logic [TS_W-1:0]  ts_q, ts_d, ts_sel;
  logic             reached, hs;
  logic [DW-1:0]    pk_d, txd_d, txd_q;
  logic [LANES-1:0] pk_c, txc_d, txc_q;
  logic             done_q;

  assign ts_sel = (st_q == S_TS) ? in_data_i[TS_W-1:0] : ts_q;

  xgtx_timer #(.CNT_W(TS_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ts_i      (ts_sel),
    .reached_o (reached)
  );

  xgtx_lane_pack #(.LEN_W(LEN_W)) u_pack (
    .rem_i  (rem_q),
    .word_i (in_data_i),
    .txd_o  (pk_d),
    .txc_o  (pk_c)
  );

  always_comb begin
    unique case (st_q)
      S_LEN, S_TS: in_ready_o = 1'b1;
      S_DATA:      in_ready_o = (rem_q != '0);
      default:     in_ready_o = 1'b0;
    endcase
  end

  assign hs = in_valid_i && in_ready_o;

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    fin_d = fin_q;
    ts_d  = ts_q;
    txd_d = W_IDLE;
    txc_d = K_ALL;
    unique case (st_q)
      S_LEN: if (hs) begin
        rem_d = in_data_i[LEN_W-1:0];
        fin_d = in_final_i;
        st_d  = S_TS;
      end
      S_TS: if (hs) begin
        ts_d = in_data_i[TS_W-1:0];
        st_d = (!paced_i || reached) ? S_SOF : S_WAIT;
      end
      S_WAIT: if (reached) st_d = S_SOF;
      S_SOF: begin
        txd_d = W_SOF;
        txc_d = 4'h1;
        st_d  = S_PRE;
      end
      S_PRE: begin
        txd_d = W_PRE;
        txc_d = 4'h0;
        st_d  = S_DATA;
      end
      S_DATA: begin
        if (rem_q == '0) begin
          // length was a multiple of the lane count: terminate-only word
          txd_d = pk_d;
          txc_d = pk_c;
          st_d  = fin_q ? S_DONE : S_LEN;
        end else if (in_valid_i) begin
          txd_d = pk_d;
          txc_d = pk_c;
          if (rem_q >= LEN_W'(LANES)) begin
            rem_d = rem_q - LEN_W'(LANES);
          end else begin
            rem_d = '0;
            st_d  = fin_q ? S_DONE : S_LEN;
          end
        end else begin
          txd_d = W_ERR;
          txc_d = K_ALL;
        end
      end
      S_DONE: ;
      default: st_d = S_LEN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_LEN;
      rem_q  <= '0;
      fin_q  <= 1'b0;
      ts_q   <= '0;
      txd_q  <= W_IDLE;
      txc_q  <= K_ALL;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      fin_q  <= fin_d;
      ts_q   <= ts_d;
      txd_q  <= txd_d;
      txc_q  <= txc_d;
      done_q <= (st_q == S_DONE);
    end
  end

  assign txd_o  = txd_q;
  assign txc_o  = txc_q;
  assign done_o = done_q;

  p_sof_then_pre_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txc_o == 4'h1) |=> (txd_o == 32'hD5555555 && txc_o == 4'h0));

  p_term_then_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txc_o == 4'h8 || txc_o == 4'hC || txc_o == 4'hE ||
     (txc_o == 4'hF && txd_o == 32'h070707FD))
    |=> (txc_o == 4'hF && txd_o == 32'h07070707));

  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (txc_o == 4'hF && txd_o == 32'h07070707 && !in_ready_o));

  p_done_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  p_stall_err_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_DATA && rem_q != '0 && !in_valid_i)
    |=> (txd_o == 32'hFEFEFEFE && txc_o == 4'hF));
endmodule

// File: tb/sim_xgmii_frame_tx.sv
module sim_xgmii_frame_tx;
  localparam int NF = 10;
  localparam int LENS [NF] = '{1, 2, 3, 4, 5, 6, 7, 8, 0, 13};
  localparam logic [31:0] IDLE = 32'h07070707;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        paced = 1'b0;
  logic        vld = 1'b0;
  logic [31:0] dat = '0;
  logic        fin = 1'b0;
  logic        rdy, done;
  logic [31:0] txd;
  logic [3:0]  txc;
  int          checks = 0, fails = 0, cyc = 0;
  bit          finished = 1'b0;

  always #2ns clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  xgmii_frame_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .paced_i(paced), .in_valid_i(vld),
    .in_data_i(dat), .in_final_i(fin), .in_ready_o(rdy),
    .txd_o(txd), .txc_o(txc), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int f, input int i);
    return 8'(f * 37 + i * 5 + 1);
  endfunction

  function automatic logic [31:0] mkword(input int f, input int w);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = pat(f, 4*w + b);
    return r;
  endfunction

  task automatic push(input logic [31:0] w, input logic fl);
    vld = 1'b1; dat = w; fin = fl;
    while (!rdy) @(negedge clk);
    @(negedge clk);
    vld = 1'b0; fin = 1'b0;
  endtask

  task automatic send_frame(input int f, input int len, input int ts, input bit fl);
    push(32'(len), fl);                       // R8 length word
    push(32'(ts), 1'b0);                      // R8 timestamp word
    for (int w = 0; w < (len + 3) / 4; w++) push(mkword(f, w), 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vld = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // called at a negedge; returns at the negedge after the terminate word
  task automatic check_frame(input int f, input int len, input bit gchk, output int sof_cyc);
    int gap = 0;
    logic [7:0] b0, b1, b2;
    while (txc == 4'hF && txd == IDLE && gap < 1000) begin
      gap++;
      @(negedge clk);
    end
    sof_cyc = cyc;
    if (gchk) chk(gap == 2, "R9 idle gap", 36'(gap), 36'd2);
    chk(txd == 32'h555555FB && txc == 4'h1, "R2 start word", {txc, txd}, {4'h1, 32'h555555FB});
    @(negedge clk);
    chk(txd == 32'hD5555555 && txc == 4'h0, "R2 preamble word", {txc, txd}, {4'h0, 32'hD5555555});
    @(negedge clk);
    for (int w = 0; w < len / 4; w++) begin
      chk(txd == mkword(f, w) && txc == 4'h0, "R3 R8 payload word", {txc, txd}, {4'h0, mkword(f, w)});
      @(negedge clk);
    end
    b0 = pat(f, 4*(len/4)); b1 = pat(f, 4*(len/4) + 1); b2 = pat(f, 4*(len/4) + 2);
    case (len % 4)
      3: chk(txd == {8'hFD, b2, b1, b0} && txc == 4'h8, "R4 term 3 left", {txc, txd}, {4'h8, 8'hFD, b2, b1, b0});
      2: chk(txd == {8'h07, 8'hFD, b1, b0} && txc == 4'hC, "R5 term 2 left", {txc, txd}, {4'hC, 8'h07, 8'hFD, b1, b0});
      1: chk(txd == {16'h0707, 8'hFD, b0} && txc == 4'hE, "R6 term 1 left", {txc, txd}, {4'hE, 16'h0707, 8'hFD, b0});
      default: chk(txd == 32'h070707FD && txc == 4'hF, "R7 term 0 left", {txc, txd}, {4'hF, 32'h070707FD});
    endcase
    @(negedge clk);
  endtask

  task automatic check_done();
    for (int k = 0; k < 5; k++) begin
      chk(done && !rdy && txc == 4'hF && txd == IDLE, "R11 done idle", {1'b0, done, rdy, txc[0], txd}, {4'b0101, IDLE});
      @(negedge clk);
    end
  endtask

  initial begin
    int sc;
    // reset state
    do_reset();
    @(negedge clk);
    chk(txd == IDLE && txc == 4'hF, "R1 idle after reset", {txc, txd}, {4'hF, IDLE});
    chk(!done, "R1 done clear", 36'(done), 36'd0);

    // back-to-back table walk
    fork
      for (int f = 0; f < NF; f++) send_frame(f, LENS[f], 0, f == NF - 1);
      for (int f = 0; f < NF; f++) check_frame(f, LENS[f], f != 0, sc);
    join
    check_done();

    // payload word held back mid-frame
    do_reset();
    @(negedge clk);
    fork
      begin
        push(32'd8, 1'b1);
        push(32'd0, 1'b0);
        push(mkword(20, 0), 1'b0);
        repeat (3) @(negedge clk);
        push(mkword(20, 1), 1'b0);
      end
      begin
        int errs = 0;
        while (txc == 4'hF && txd == IDLE) @(negedge clk);
        chk(txc == 4'h1, "R2 start before stall", {txc, txd}, {4'h1, 32'h555555FB});
        repeat (2) @(negedge clk);
        chk(txd == mkword(20, 0) && txc == 4'h0, "R3 word before stall", {txc, txd}, {4'h0, mkword(20, 0)});
        @(negedge clk);
        while (txc == 4'hF && txd == 32'hFEFEFEFE && errs < 50) begin
          errs++;
          @(negedge clk);
        end
        chk(errs == 3, "R12 error word count", 36'(errs), 36'd3);
        chk(txd == mkword(20, 1) && txc == 4'h0, "R12 resume word", {txc, txd}, {4'h0, mkword(20, 1)});
        @(negedge clk);
        chk(txd == 32'h070707FD && txc == 4'hF, "R7 term after stall", {txc, txd}, {4'hF, 32'h070707FD});
        @(negedge clk);
        check_done();
      end
    join

    // paced mode; reset must restart the counter (R1)
    paced = 1'b1;
    do_reset();
    @(negedge clk);
    fork
      begin
        send_frame(30, 5, 150, 1'b0);
        send_frame(31, 2, 20, 1'b1);
      end
      begin
        check_frame(30, 5, 1'b0, sc);
        chk(sc == 152, "R10 R1 paced start cycle", 36'(sc), 36'd152);
        check_frame(31, 2, 1'b1, sc);
      end
    join
    check_done();

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4ns * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule